// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block carries 8-bit PCM samples between a codec core and a pair of serial PCM buses. A bit clock paces both buses. Separate transmit and receive frame-sync inputs mark the start of each direction's frame, and the two frames may be skewed by any whole number of bit clocks. In delayed timing, a per-direction slot counter restarts on every frame-sync leading edge and selects the programmed slot. In non-delayed timing the slot begins at the frame sync itself, and the programmed slot number has no effect.

During its transmit slot the block drives the serial output, most significant bit first, on rising bit-clock edges. It raises an output-enable for the pad and pulls an active-low line-driver enable low for the first seven and a half bit times. During its receive slot it samples the serial input on falling edges and presents the completed byte with a one-cycle valid pulse. A power-down input silences both directions. After power returns, transmission waits until the second transmit frame sync.

The bit clock and frame syncs are assumed to be synchronous to the system clock, and much slower than it. Both bit-clock phases must last at least two system clocks. The pad tri-state is built from the data and output-enable pair. Slot, enable and timing-mode inputs come from registers held elsewhere and are stable during a frame.

Top module: `pcm_tsi`

## Requirements
- R1: During and after reset, `tx_serial_oe` is 0, `tx_serial_out` is 0, `line_drv_en_n` is 1, `rx_sample_vld` is 0 and `rx_sample` is 0.
- R2: With `delayed_mode`=0, the rising bit-clock edge on which a frame sync is first seen high is bit 0 of slot 0. Slot 0 is used in that direction whatever the slot number input holds.
- R3: With `delayed_mode`=1, a frame sync first seen high at a falling bit-clock edge makes the next rising edge bit 0 of slot 0. Slot N begins 8·N rising edges later and is used when the slot number equals N.
- R4: In the transmit slot, `tx_serial_oe` is 1 for exactly the 8 bit times. `tx_serial_out` carries `tx_sample` bit 7 first, down to bit 0, each bit changing after a rising edge. The value is taken at the first bit of the slot. Outside the slot, `tx_serial_oe` and `tx_serial_out` are 0.
- R5: `line_drv_en_n` goes low after the first rising edge of the transmit slot. It returns high after the falling edge inside the slot's eighth bit, so it is low for 7.5 bit times.
- R6: In the receive slot, `rx_serial_in` is sampled on each falling edge, first bit into bit 7. After the eighth sample, `rx_sample` holds the byte and `rx_sample_vld` pulses for exactly one system clock.
- R7: Transmit and receive frames run from their own frame syncs. A skew of whole bit clocks between the two leaves each direction's slot timing unchanged.
- R8: A slot number of `NUM_SLOTS` or more never matches. No transmit, no driver enable and no receive pulse occur in that frame.
- R9: With `tx_slot_en`=0 the transmit outputs stay inactive. With `rx_slot_en`=0 no receive pulse occurs and `rx_sample` is unchanged.
- R10: While `power_down`=1 the transmit outputs are inactive, no receive pulse occurs and `rx_sample` is unchanged. After `power_down` falls, or after reset, the transmit outputs stay inactive until the frame started by the second transmit frame-sync leading edge. Receive resumes at once.
- R11: Only a frame sync's leading edge counts. Holding it high for several bit times neither restarts nor shifts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock, synchronous to `clk` |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| delayed_mode | input | 1 | 1 = delayed timing with slot counters, 0 = non-delayed |
| power_down | input | 1 | 1 = both directions inactive |
| tx_slot | input | SEL_W | Transmit slot number (delayed timing) |
| tx_slot_en | input | 1 | Transmit direction enable |
| rx_slot | input | SEL_W | Receive slot number (delayed timing) |
| rx_slot_en | input | 1 | Receive direction enable |
| tx_sample | input | 8 | Byte to transmit |
| rx_serial_in | input | 1 | Receive serial data |
| tx_serial_out | output | 1 | Transmit serial data |
| tx_serial_oe | output | 1 | Output enable for the transmit pad (0 = high impedance) |
| line_drv_en_n | output | 1 | Active-low backplane line-driver enable |
| rx_sample | output | 8 | Last received byte |
| rx_sample_vld | output | 1 | One-cycle pulse when `rx_sample` is updated |

## Verification
The release of the line-driver enable and the completion of a received byte both happen on a falling bit-clock edge. They fall on the same edge when both directions use the same slot number with zero frame skew. The sweep hits this case for slot numbers 0 and 3 in both timing modes. In those frames the bench checks the driver enable after every phase of every bit, and it checks the receive pulse count and byte. Either action getting lost or corrupted when they coincide shows up as a mismatch. Skewed frames in the same sweep separate the two events, so the same checks also cover the case where they do not coincide.

// File: rtl/pcm_tsi_pkg.sv
// Shared constants, helper function and strobe type for the PCM time-slot
// interface. Assumes 8-bit slots.
package pcm_tsi_pkg;

    localparam int SLOT_BITS = 8;
    localparam int BIT_IDX_W = 3;

    // Width of a counter that spans every bit position of a frame.
    function automatic int pos_width(input int num_slots);
        return $clog2(num_slots * SLOT_BITS);
    endfunction

    // Registered bit-clock strobes for one direction, valid together with
    // the timer state they describe.
    typedef struct packed {
        logic tick_r;       // a rising bit-clock edge was just processed
        logic tick_f;       // a falling bit-clock edge was just processed
        logic frame_start;  // the processed rising edge was bit 0 of slot 0
    } slot_strobe_t;

endpackage

// File: rtl/pcm_bclk_edge.sv
// Bit-clock edge detector. It turns the bit-clock level into one-cycle rise
// and fall strobes in the system clock domain. Assumes bit_clk is already
// synchronous to clk and that each phase lasts at least two clk cycles.
module pcm_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk,
    output logic rise,
    output logic fall
);

    logic bclk_q;

    // Remember the bit-clock level of the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bit_clk;
    end

    assign rise = bit_clk & ~bclk_q;
    assign fall = ~bit_clk & bclk_q;

endmodule

// File: rtl/pcm_slot_timer.sv
// Per-direction frame and slot timer. It tracks the bit position within
// the frame from the frame-sync leading edge. In delayed timing it uses the
// sync seen at a falling edge, with counter-based slot selection. In
// non-delayed timing it uses the sync seen at a rising edge, with slot 0
// only. The counter stops after the last slot until the next sync.
// Assumes NUM_SLOTS >= 2 and configuration stable during a frame.
module pcm_slot_timer
    import pcm_tsi_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SEL_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 fsync,
    input  logic                 delayed,
    input  logic [SEL_W-1:0]     slot_sel,
    input  logic                 slot_en,
    output slot_strobe_t         strobe,
    output logic                 in_slot,
    output logic [BIT_IDX_W-1:0] bit_idx
);

    localparam int POS_W    = pos_width(NUM_SLOTS);
    localparam int SLOT_FW  = POS_W - BIT_IDX_W;
    localparam int LAST_POS = NUM_SLOTS * SLOT_BITS - 1;
    localparam int CW       = SEL_W + SLOT_FW;

    logic             fs_at_rise;
    logic             fs_at_fall;
    logic             armed;
    logic             active;
    logic [POS_W-1:0] pos;
    logic             start;
    logic             slot_hit;

    // A frame begins on a rising edge: armed by a falling-edge sync, or a fresh sync.
    assign start = delayed ? armed : (fsync & ~fs_at_rise);

    // Advance the frame position on rising edges and arm on delayed syncs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_at_rise          <= 1'b0;
            fs_at_fall          <= 1'b0;
            armed               <= 1'b0;
            active              <= 1'b0;
            pos                 <= '0;
            strobe.tick_r       <= 1'b0;
            strobe.tick_f       <= 1'b0;
            strobe.frame_start  <= 1'b0;
        end else begin
            strobe.tick_r      <= rise;
            strobe.tick_f      <= fall;
            strobe.frame_start <= rise & start;
            if (rise) begin
                fs_at_rise <= fsync;
                armed      <= 1'b0;
                if (start) begin
                    pos    <= '0;
                    active <= 1'b1;
                end else if (active) begin
                    if (pos == POS_W'(LAST_POS)) active <= 1'b0;
                    else                         pos    <= pos + POS_W'(1);
                end
            end
            if (fall) begin
                fs_at_fall <= fsync;
                if (delayed && fsync && !fs_at_fall) armed <= 1'b1;
            end
        end
    end

    // Compare the current slot with the programmed one (slot 0 when not delayed).
    always_comb begin
        if (delayed) slot_hit = (CW'(pos[POS_W-1:BIT_IDX_W]) == CW'(slot_sel));
        else         slot_hit = (pos[POS_W-1:BIT_IDX_W] == '0);
    end

    assign in_slot = active & slot_en & slot_hit;
    assign bit_idx = pos[BIT_IDX_W-1:0];

    // R3: within a running frame every processed rising edge advances by one bit.
    assert_pos_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.tick_r && active && !strobe.frame_start) |-> (pos == $past(pos) + POS_W'(1)));

    // R3: a frame start always leaves the timer running from position zero.
    assert_start_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.frame_start |-> (active && pos == '0));

endmodule

// File: rtl/pcm_tx_shifter.sv
// Transmit slot shifter. It loads the sample at the first bit of the
// assigned slot and shifts it out MSB first on processed rising edges. It
// drives the pad enable and the active-low line-driver enable; the latter is
// released at the falling edge inside bit 7. It also gates transmission
// after power-up until the second frame start.
module pcm_tx_shifter
    import pcm_tsi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_strobe_t         strobe,
    input  logic                 in_slot,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic                 power_down,
    input  logic [7:0]           sample,
    output logic                 ser_out,
    output logic                 ser_oe,
    output logic                 drv_n
);

    logic [1:0] syncs_seen;
    logic [1:0] syncs_next;
    logic       go;
    logic [7:0] shreg;

    // Count frame starts since power-up, saturating at two.
    always_comb begin
        syncs_next = syncs_seen;
        if (strobe.frame_start && syncs_seen != 2'd2) syncs_next = syncs_seen + 2'd1;
    end
    assign go = (syncs_next == 2'd2);

    // Track frame syncs seen since the last power-down or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || power_down) syncs_seen <= 2'd0;
        else                      syncs_seen <= syncs_next;
    end

    // Drive serial data, pad enable and driver enable across the slot.
    always_ff @(posedge clk) begin
        if (!rst_n || power_down) begin
            ser_out <= 1'b0;
            ser_oe  <= 1'b0;
            drv_n   <= 1'b1;
            shreg   <= '0;
        end else begin
            if (strobe.tick_r) begin
                if (in_slot && bit_idx == '0 && go) begin
                    ser_oe  <= 1'b1;
                    ser_out <= sample[7];
                    shreg   <= {sample[6:0], 1'b0};
                    drv_n   <= 1'b0;
                end else if (in_slot && ser_oe) begin
                    ser_out <= shreg[7];
                    shreg   <= {shreg[6:0], 1'b0};
                end else begin
                    ser_oe  <= 1'b0;
                    ser_out <= 1'b0;
                    drv_n   <= 1'b1;
                end
            end
            if (strobe.tick_f && in_slot && bit_idx == BIT_IDX_W'(7)) drv_n <= 1'b1;
        end
    end

    // R5: the line driver is only enabled while the slot is being driven.
    assert_drv_inside_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_n |-> ser_oe);

    // R10: power-down silences the transmit outputs on the next cycle.
    assert_quiet_after_pwrdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!ser_oe && drv_n));

    // R10: transmission only happens once two frame syncs have been seen.
    assert_oe_after_two_syncs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (syncs_seen == 2'd2));

endmodule

// File: rtl/pcm_rx_shifter.sv
// Receive slot shifter. It samples the serial input at each processed
// falling edge of the assigned slot, MSB first. After the eighth sample it
// updates the output byte and emits a one-cycle valid pulse. Inactive while
// powered down.
module pcm_rx_shifter
    import pcm_tsi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_strobe_t         strobe,
    input  logic                 in_slot,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic                 power_down,
    input  logic                 ser_in,
    output logic [7:0]           byte_out,
    output logic                 byte_vld
);

    logic [6:0] shreg;

    // Assemble bits on falling edges and publish the byte after bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (strobe.tick_f && in_slot && !power_down) begin
                shreg <= {shreg[5:0], ser_in};
                if (bit_idx == BIT_IDX_W'(7)) begin
                    byte_out <= {shreg, ser_in};
                    byte_vld <= 1'b1;
                end
            end
        end
    end

    // R6: the valid indication never lasts longer than one cycle.
    assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R6: a byte only completes right after a processed falling edge.
    assert_vld_follows_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(strobe.tick_f));

endmodule

// File: rtl/pcm_tsi.sv
// PCM time-slot serial interface top. It shares one bit-clock edge
// detector between an independent transmit timer/shifter pair and receive
// timer/shifter pair. Assumes all inputs are synchronous to clk and that
// configuration changes only between frames.
module pcm_tsi
    import pcm_tsi_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SEL_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic             tx_fsync,
    input  logic             rx_fsync,
    input  logic             delayed_mode,
    input  logic             power_down,
    input  logic [SEL_W-1:0] tx_slot,
    input  logic             tx_slot_en,
    input  logic [SEL_W-1:0] rx_slot,
    input  logic             rx_slot_en,
    input  logic [7:0]       tx_sample,
    input  logic             rx_serial_in,
    output logic             tx_serial_out,
    output logic             tx_serial_oe,
    output logic             line_drv_en_n,
    output logic [7:0]       rx_sample,
    output logic             rx_sample_vld
);

    logic                 rise;
    logic                 fall;
    logic                 rx_in_q;
    slot_strobe_t         tx_strobe;
    slot_strobe_t         rx_strobe;
    logic                 tx_in_slot;
    logic                 rx_in_slot;
    logic [BIT_IDX_W-1:0] tx_bit;
    logic [BIT_IDX_W-1:0] rx_bit;

    pcm_bclk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_clk (bit_clk),
        .rise    (rise),
        .fall    (fall)
    );

    // Align the receive data with the registered falling-edge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_in_q <= 1'b0;
        else        rx_in_q <= rx_serial_in;
    end

    pcm_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_tx_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .fsync    (tx_fsync),
        .delayed  (delayed_mode),
        .slot_sel (tx_slot),
        .slot_en  (tx_slot_en),
        .strobe   (tx_strobe),
        .in_slot  (tx_in_slot),
        .bit_idx  (tx_bit)
    );

    pcm_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_rx_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .fsync    (rx_fsync),
        .delayed  (delayed_mode),
        .slot_sel (rx_slot),
        .slot_en  (rx_slot_en),
        .strobe   (rx_strobe),
        .in_slot  (rx_in_slot),
        .bit_idx  (rx_bit)
    );

    pcm_tx_shifter u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (tx_strobe),
        .in_slot    (tx_in_slot),
        .bit_idx    (tx_bit),
        .power_down (power_down),
        .sample     (tx_sample),
        .ser_out    (tx_serial_out),
        .ser_oe     (tx_serial_oe),
        .drv_n      (line_drv_en_n)
    );

    pcm_rx_shifter u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (rx_strobe),
        .in_slot    (rx_in_slot),
        .bit_idx    (rx_bit),
        .power_down (power_down),
        .ser_in     (rx_in_q),
        .byte_out   (rx_sample),
        .byte_vld   (rx_sample_vld)
    );

    // R1: coming out of reset the transmit side is idle.
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_serial_oe && line_drv_en_n && !rx_sample_vld));

endmodule

// File: tb/test_pcm_tsi.sv
`timescale 1ns/1ps
module test_pcm_tsi;

    localparam int NS = 4;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_clk = 1'b0;
    logic          tx_fsync = 1'b0;
    logic          rx_fsync = 1'b0;
    logic          delayed_mode = 1'b0;
    logic          power_down = 1'b0;
    logic [SW-1:0] tx_slot = '0;
    logic          tx_slot_en = 1'b1;
    logic [SW-1:0] rx_slot = '0;
    logic          rx_slot_en = 1'b1;
    logic [7:0]    tx_sample = '0;
    logic          rx_serial_in = 1'b0;
    logic          tx_serial_out;
    logic          tx_serial_oe;
    logic          line_drv_en_n;
    logic [7:0]    rx_sample;
    logic          rx_sample_vld;

    int n_chk = 0;
    int n_fail = 0;
    int vld_cnt = 0;
    int up_frames = 0;
    logic [7:0] last_rx = 8'h00;
    bit done = 0;

    always #2 clk = ~clk;

    pcm_tsi #(.NUM_SLOTS(NS), .SEL_W(SW)) i_pcm_tsi (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .tx_fsync(tx_fsync),
        .rx_fsync(rx_fsync), .delayed_mode(delayed_mode), .power_down(power_down),
        .tx_slot(tx_slot), .tx_slot_en(tx_slot_en), .rx_slot(rx_slot),
        .rx_slot_en(rx_slot_en), .tx_sample(tx_sample), .rx_serial_in(rx_serial_in),
        .tx_serial_out(tx_serial_out), .tx_serial_oe(tx_serial_oe),
        .line_drv_en_n(line_drv_en_n), .rx_sample(rx_sample),
        .rx_sample_vld(rx_sample_vld)
    );

    // Count receive pulses away from the active edge.
    always @(negedge clk) if (rst_n && rx_sample_vld) vld_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string dir_tag(input bit dly, input int sel, input int fsw,
                                      input bit en, input bit live, input int ofs);
        if (!live)               return "R10";
        if (!en)                 return "R9";
        if (dly && sel >= NS)    return "R8";
        if (ofs > 0)             return "R7";
        if (fsw > 1)             return "R11";
        if (dly)                 return "R3";
        return "R2";
    endfunction

    // One frame per direction; tx frame starts at bit 1, rx frame at bit 1+ofs.
    task automatic run_frame(input bit dly, input int tsel, input int rsel,
                             input int ofs, input int fsw,
                             input logic [7:0] tbyte, input logic [7:0] rbyte,
                             input bit ten, input bit ren);
        int  st = 1;
        int  sr = 1 + ofs;
        int  teff = dly ? tsel : 0;
        int  reff = dly ? rsel : 0;
        bit  tx_live, rx_live, tx_act, rx_act;
        int  len = 34 + ofs;
        string ttag, rtag;
        @(negedge clk);
        delayed_mode = dly;
        tx_slot = SW'(tsel);
        rx_slot = SW'(rsel);
        tx_slot_en = ten;
        rx_slot_en = ren;
        tx_sample = tbyte;
        if (!power_down) up_frames++;
        tx_live = !power_down && up_frames >= 2;
        rx_live = !power_down;
        tx_act = ten && tx_live && teff < NS;
        rx_act = ren && rx_live && reff < NS;
        ttag = dir_tag(dly, tsel, fsw, ten, tx_live, 0);
        rtag = dir_tag(dly, rsel, fsw, ren, rx_live, ofs);
        vld_cnt = 0;
        for (int p = 0; p < len; p++) begin
            int  kt = p - st - 8 * teff;
            int  kr = p - sr - 8 * reff;
            bit  in_t = tx_act && kt >= 0 && kt < 8;
            bit  in_r = kr >= 0 && kr < 8 && reff < NS;
            bit  exp_bit;
            tx_fsync = dly ? (p >= st - 1 && p < st - 1 + fsw) : (p >= st && p < st + fsw);
            rx_fsync = dly ? (p >= sr - 1 && p < sr - 1 + fsw) : (p >= sr && p < sr + fsw);
            rx_serial_in = in_r ? rbyte[7 - kr] : (p[0] ^ p[1]);
            bit_clk = 1'b1;
            repeat (4) @(negedge clk);
            exp_bit = in_t ? tbyte[7 - kt] : 1'b0;
            chk(tx_serial_oe == in_t, ttag, "tx pad enable", tx_serial_oe, in_t);
            chk(tx_serial_out == exp_bit, "R4", "tx serial bit", tx_serial_out, exp_bit);
            chk(line_drv_en_n == !in_t, "R5", "driver enable high phase", line_drv_en_n, !in_t);
            bit_clk = 1'b0;
            repeat (4) @(negedge clk);
            chk(line_drv_en_n == !(in_t && kt < 7), "R5", "driver enable low phase",
                line_drv_en_n, !(in_t && kt < 7));
        end
        tx_fsync = 1'b0;
        rx_fsync = 1'b0;
        repeat (3) @(negedge clk);
        chk(vld_cnt == int'(rx_act), rtag, "rx valid pulses", vld_cnt, int'(rx_act));
        if (rx_act) last_rx = rbyte;
        chk(rx_sample == last_rx, "R6", "rx byte", rx_sample, last_rx);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(tx_serial_oe == 1'b0 && tx_serial_out == 1'b0, "R1", "tx idle in reset",
            tx_serial_oe, 0);
        chk(line_drv_en_n == 1'b1, "R1", "driver disabled in reset", line_drv_en_n, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_sample_vld == 1'b0 && rx_sample == 8'h00, "R1", "rx idle after reset",
            rx_sample, 0);
        chk(tx_serial_oe == 1'b0 && line_drv_en_n == 1'b1, "R1", "tx idle after reset",
            tx_serial_oe, 0);

        // Sweep timing modes, slot numbers (including out-of-range) and skews.
        for (int d = 0; d < 2; d++) begin
            for (int ts = 0; ts < 6; ts++) begin
                for (int oi = 0; oi < 2; oi++) begin
                    int ofs = oi * 3;
                    int rs = (ts * 3 + ofs) % 6;
                    int fsw = (ts % 2 == 1) ? 3 : 1;
                    logic [7:0] tb = 8'(8'hA5 ^ (ts * 37 + ofs + d * 11));
                    logic [7:0] rb = 8'(8'h3C ^ (ts * 53 + ofs * 7 + d));
                    run_frame(d[0], ts, rs, ofs, fsw, tb, rb, 1'b1, 1'b1);
                end
            end
        end

        // R9: direction enables switched off one at a time.
        run_frame(1'b1, 2, 1, 0, 1, 8'hF0, 8'h5A, 1'b0, 1'b1);
        run_frame(1'b1, 2, 1, 2, 1, 8'h0F, 8'hC3, 1'b1, 1'b0);

        // R10: power-down frame, then two frames after power-up.
        @(negedge clk);
        power_down = 1'b1;
        up_frames = 0;
        run_frame(1'b1, 1, 1, 0, 1, 8'h81, 8'h99, 1'b1, 1'b1);
        @(negedge clk);
        power_down = 1'b0;
        run_frame(1'b1, 1, 2, 1, 1, 8'h42, 8'h24, 1'b1, 1'b1);
        run_frame(1'b1, 1, 2, 1, 2, 8'hE7, 8'h18, 1'b1, 1'b1);
        run_frame(1'b0, 3, 0, 0, 1, 8'h6B, 8'hD6, 1'b1, 1'b1);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(1'b0, "ALL", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule